// File: doc/BRIEF.md
# Register-Driven MDIO Management Master

This block is a management-interface master for PHY devices. It is reached through a small word-addressed register port. Each MDIO bus has three registers. The command register holds the PHY address, register index, opcode, start code, turnaround code and two clock-divider fields. A write-value register holds the 16 bits sent by a write frame. A status register reports a busy flag and the 16 bits captured by the most recent read frame. There are `NBUS` (default two) buses that do not affect each other. Their registers repeat at a 4-byte stride inside each register group.

Software loads the write value first. It then writes the command with the launch bit cleared, and then writes it again with the launch bit set. Only a clear-to-set change of the stored launch bit starts a frame, so a launch bit left set from an earlier command does nothing until software clears it. A frame has 64 bits, sent most significant bit first: 32 ones, then the start code, opcode, PHY address, register index, turnaround code and 16 data bits. Setting the reset bit in the command register stops any frame at once and holds that bus idle. The other command fields, the divider settings among them, stay as written.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, every command, write-value and status register reads zero, and every bus has `mdc` low and `mdioOe` low.
- R2: A frame starts only on a write to a command register (byte offset 0x00 + 4*bus) that sets bit 24 (launch) while the stored bit 24 is 0. A write that sets bit 24 while it is already set starts nothing.
- R3: The frame is sent MSB first as 32 ones, start code (command bits 13:12), opcode (11:10), PHY address (4:0), register index (9:5), turnaround (15:14), then 16 data bits. For a write, the data bits are the write-value register (offset 0x10 + 4*bus, bits 15:0). `mdioOut` changes only while `mdc` is low.
- R4: Each half period of `mdc` lasts (D+1)*(P+1) system clocks. D is command bits 19:16 and P is bits 21:20, both latched when the frame starts. A frame begins with `mdc` low, and `mdc` stays low whenever no frame is running.
- R5: For opcode 2 (read), `mdioOe` drops at the first turnaround bit (frame bit 46) and stays low to the end of the frame. `mdioIn` is sampled as `mdc` rises during the last 16 bits. After the frame, the result is in status bits 15:0 (offset 0x20 + 4*bus).
- R6: Status bit 16 (busy) is high from the cycle after the starting write for exactly 128*(D+1)*(P+1) cycles.
- R7: A clear-then-set of the launch bit while busy is high is ignored. The running frame's bits, length and divider stay unchanged.
- R8: Writing the command register with bit 31 set ends busy, `mdc` and `mdioOe` at the next clock edge. Writing it again with bit 31 clear leaves the bus idle with the written divider fields intact.
- R9: A frame on one bus leaves the `mdc` of the other buses low, and each bus keeps its own registers.
- R10: Any opcode other than 2 drives `mdioOe` high for all 64 bits and leaves the status data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Byte address for writes and for the combinational read |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for `regAddr` |
| mdioIn | input | NBUS | Sensed MDIO line, one per bus |
| mdc | output | NBUS | Management clock, one per bus |
| mdioOut | output | NBUS | Driven MDIO value, one per bus |
| mdioOe | output | NBUS | MDIO output enable, one per bus |

## Verification
The hardest situations to reach are the two mid-frame command writes: a clear-then-set of the launch bit while busy, and a soft reset that cuts a frame short. From the ports alone these need register writes timed to a chosen busy cycle. The bench monitor can fire one or two command writes at a set count of busy cycles while it keeps recording every `mdc` rising edge. It then checks that the recorded frame and its length match the original command, or that busy ended on the expected cycle. Random frames spread over both buses, all four opcodes and several divider settings cover the shifting and sampling paths.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int PREAMBLE_BITS = 32;
  localparam int PHY_W         = 5;
  localparam int REGIDX_W      = 5;
  localparam int DATA_W        = 16;
  localparam int DIV_W         = 4;
  localparam int PRE_W         = 2;
  localparam int FRAME_BITS    = PREAMBLE_BITS + 2 + 2 + PHY_W + REGIDX_W + 2 + DATA_W;
  localparam int BIT_W         = $clog2(FRAME_BITS);
  localparam int TA_FIRST      = PREAMBLE_BITS + 4 + PHY_W + REGIDX_W;
  localparam int DATA_FIRST    = TA_FIRST + 2;
  localparam int HP_W          = DIV_W + PRE_W + 1;

  localparam logic [1:0] OP_READ = 2'd2;

  localparam int LOAD_BIT = 24;
  localparam int RST_BIT  = 31;
  localparam logic [31:0] CTRL_MASK = 32'h813F_FFFF;

  localparam int CTRL_OFS = 'h00;
  localparam int DATA_OFS = 'h10;
  localparam int STAT_OFS = 'h20;

  typedef struct packed {
    logic [PRE_W-1:0]    pre;
    logic [DIV_W-1:0]    div;
    logic [1:0]          ta;
    logic [1:0]          st;
    logic [1:0]          op;
    logic [REGIDX_W-1:0] regIdx;
    logic [PHY_W-1:0]    phy;
  } cmdFields_t;

  typedef struct packed {
    logic             active;
    logic             launch;
    logic             shift;
    logic             sample;
    logic             finish;
    logic [BIT_W-1:0] bitIdx;
  } seqStrobe_t;
endpackage

// File: rtl/mdio_mgmt_regs.sv
module mdio_mgmt_regs
  import mdio_mgmt_pkg::*;
#(
  parameter int NBUS   = 2,
  parameter int ADDR_W = 8
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           wrEn,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [31:0]                    wrData,
  output logic [31:0]                    rdData,
  input  logic [NBUS-1:0]                busy,
  input  logic [NBUS-1:0][DATA_W-1:0]    rdVal,
  output cmdFields_t [NBUS-1:0]          cmd,
  output logic [NBUS-1:0][DATA_W-1:0]    wrVal,
  output logic [NBUS-1:0]                launch,
  output logic [NBUS-1:0]                abort
);
  logic [NBUS-1:0][31:0] ctrlQ;

  for (genvar b = 0; b < NBUS; b++) begin : g_bus
    logic hitCtrl, hitData;
    assign hitCtrl = wrEn && (addr == ADDR_W'(CTRL_OFS + 4 * b));
    assign hitData = wrEn && (addr == ADDR_W'(DATA_OFS + 4 * b));

    assign launch[b] = hitCtrl && wrData[LOAD_BIT] && !ctrlQ[b][LOAD_BIT]
                       && !wrData[RST_BIT] && !busy[b];
    assign abort[b]  = (hitCtrl && wrData[RST_BIT]) || ctrlQ[b][RST_BIT];
    assign cmd[b]    = cmdFields_t'(ctrlQ[b][$bits(cmdFields_t)-1:0]);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        ctrlQ[b] <= '0;
        wrVal[b] <= '0;
      end else begin
        if (hitCtrl) ctrlQ[b] <= wrData & CTRL_MASK;
        if (hitData) wrVal[b] <= wrData[DATA_W-1:0];
      end
    end

    assert_soft_reset_R8: assert property (@(posedge clk) disable iff (!rstN)
      ctrlQ[b][RST_BIT] |-> !busy[b]);
  end

  always_comb begin
    rdData = '0;
    for (int b = 0; b < NBUS; b++) begin
      if (addr == ADDR_W'(CTRL_OFS + 4 * b)) rdData = ctrlQ[b];
      if (addr == ADDR_W'(DATA_OFS + 4 * b)) rdData = {16'b0, wrVal[b]};
      if (addr == ADDR_W'(STAT_OFS + 4 * b)) rdData = {15'b0, busy[b], rdVal[b]};
    end
  end
endmodule

// File: rtl/mdio_mgmt_seq.sv
module mdio_mgmt_seq
  import mdio_mgmt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             launch,
  input  logic             abort,
  input  logic [DIV_W-1:0] div,
  input  logic [PRE_W-1:0] pre,
  output seqStrobe_t       strb,
  output logic             mdc
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_BITS - 1);

  logic             active, phaseHigh, tick;
  logic [HP_W-1:0]  halfQ, cnt, halfLen;
  logic [BIT_W-1:0] bitIdx;

  assign halfLen = HP_W'(int'(div) + 1) * HP_W'(int'(pre) + 1);
  assign tick    = active && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active <= 1'b0; phaseHigh <= 1'b0; cnt <= '0; halfQ <= '0; bitIdx <= '0;
    end else if (abort) begin
      active <= 1'b0; phaseHigh <= 1'b0; cnt <= '0; bitIdx <= '0;
    end else if (launch) begin
      active    <= 1'b1;
      phaseHigh <= 1'b0;
      bitIdx    <= '0;
      halfQ     <= halfLen;
      cnt       <= halfLen - 1'b1;
    end else if (active) begin
      if (tick) begin
        cnt       <= halfQ - 1'b1;
        phaseHigh <= !phaseHigh;
        if (phaseHigh) begin
          if (bitIdx == LAST_BIT) active <= 1'b0;
          else bitIdx <= bitIdx + 1'b1;
        end
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign strb.active = active;
  assign strb.launch = launch && !abort;
  assign strb.sample = tick && !phaseHigh;
  assign strb.shift  = tick && phaseHigh && (bitIdx != LAST_BIT);
  assign strb.finish = tick && phaseHigh && (bitIdx == LAST_BIT);
  assign strb.bitIdx = bitIdx;
  assign mdc         = active && phaseHigh;

  assert_no_restart_R7: assert property (@(posedge clk) disable iff (!rstN)
    (active && !strb.finish && !abort) |=> (active && bitIdx >= $past(bitIdx)));

  assert_frame_end_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(active) && !$past(abort)) |-> ($past(bitIdx) == LAST_BIT && !mdc));
endmodule

// File: rtl/mdio_mgmt_frame.sv
module mdio_mgmt_frame
  import mdio_mgmt_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobe_t          strb,
  input  logic [PHY_W-1:0]    phy,
  input  logic [REGIDX_W-1:0] regIdx,
  input  logic [1:0]          op,
  input  logic [1:0]          st,
  input  logic [1:0]          ta,
  input  logic [DATA_W-1:0]   wrVal,
  input  logic                mdioIn,
  output logic                mdioOut,
  output logic                mdioOe,
  output logic [DATA_W-1:0]   rdVal
);
  logic [FRAME_BITS-1:0] frameSr;
  logic [DATA_W-1:0]     capSr;
  logic                  isRead;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameSr <= '0; capSr <= '0; rdVal <= '0; isRead <= 1'b0;
    end else begin
      if (strb.launch) begin
        frameSr <= {{PREAMBLE_BITS{1'b1}}, st, op, phy, regIdx, ta, wrVal};
        isRead  <= (op == OP_READ);
      end else if (strb.shift) begin
        frameSr <= {frameSr[FRAME_BITS-2:0], 1'b0};
      end
      if (strb.sample && isRead && strb.bitIdx >= BIT_W'(DATA_FIRST))
        capSr <= {capSr[DATA_W-2:0], mdioIn};
      if (strb.finish && isRead)
        rdVal <= capSr;
    end
  end

  assign mdioOut = frameSr[FRAME_BITS-1];
  assign mdioOe  = strb.active && !(isRead && strb.bitIdx >= BIT_W'(TA_FIRST));

  assert_oe_release_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(mdioOe) && strb.active) |-> (isRead && strb.bitIdx == BIT_W'(TA_FIRST)));
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_mgmt_pkg::*;
#(
  parameter int NBUS   = 2,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic [NBUS-1:0]   mdioIn,
  output logic [NBUS-1:0]   mdc,
  output logic [NBUS-1:0]   mdioOut,
  output logic [NBUS-1:0]   mdioOe
);
  cmdFields_t [NBUS-1:0]       cmd;
  logic [NBUS-1:0][DATA_W-1:0] wrVal, rdVal;
  logic [NBUS-1:0]             busy, launch, abort;

  mdio_mgmt_regs #(.NBUS(NBUS), .ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rstN(rstN), .wrEn(regWrEn), .addr(regAddr), .wrData(regWrData),
    .rdData(regRdData), .busy(busy), .rdVal(rdVal), .cmd(cmd), .wrVal(wrVal),
    .launch(launch), .abort(abort)
  );

  for (genvar b = 0; b < NBUS; b++) begin : g_bus
    seqStrobe_t strb;

    mdio_mgmt_seq seq_i (
      .clk(clk), .rstN(rstN), .launch(launch[b]), .abort(abort[b]),
      .div(cmd[b].div), .pre(cmd[b].pre), .strb(strb), .mdc(mdc[b])
    );

    mdio_mgmt_frame frame_i (
      .clk(clk), .rstN(rstN), .strb(strb), .phy(cmd[b].phy), .regIdx(cmd[b].regIdx),
      .op(cmd[b].op), .st(cmd[b].st), .ta(cmd[b].ta), .wrVal(wrVal[b]),
      .mdioIn(mdioIn[b]), .mdioOut(mdioOut[b]), .mdioOe(mdioOe[b]), .rdVal(rdVal[b])
    );

    assign busy[b] = strb.active;

    assert_stable_high_R3: assert property (@(posedge clk) disable iff (!rstN)
      (mdc[b] && $past(mdc[b])) |-> $stable(mdioOut[b]));
  end
endmodule

// File: tb/mdio_mgmt_master_tb.sv
`timescale 1ns/100ps
module mdio_mgmt_master_tb_top;
  localparam int NBUS = 2;
  localparam int AW   = 8;
  localparam logic [31:0] LOADB = 32'h0100_0000;
  localparam logic [31:0] RSTB  = 32'h8000_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [AW-1:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [NBUS-1:0] mdioIn = '1;
  logic [NBUS-1:0] mdc, mdioOut, mdioOe;

  int checks = 0;
  int failures = 0;
  logic [15:0] expRd [NBUS];

  always #2.5 clk = ~clk;

  mdio_mgmt_master #(.NBUS(NBUS), .ADDR_W(AW)) dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .mdioIn(mdioIn), .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe)
  );

  function automatic logic [AW-1:0] ctrlA(input int b); return AW'(8'h00 + 4 * b); endfunction
  function automatic logic [AW-1:0] dataA(input int b); return AW'(8'h10 + 4 * b); endfunction
  function automatic logic [AW-1:0] statA(input int b); return AW'(8'h20 + 4 * b); endfunction

  function automatic logic [31:0] mkCtrl(input logic [4:0] phy, input logic [4:0] ri,
                                         input logic [1:0] op, input logic [3:0] dv,
                                         input logic [1:0] pr);
    return {8'b0, 2'b0, pr, dv, 2'd2, 2'd1, op, ri, phy};
  endfunction

  function automatic logic [63:0] expFrame(input logic [31:0] c, input logic [15:0] w);
    return {32'hFFFF_FFFF, c[13:12], c[11:10], c[4:0], c[9:5], c[15:14], w};
  endfunction

  function automatic int halfOf(input logic [31:0] c);
    return (int'(c[19:16]) + 1) * (int'(c[21:20]) + 1);
  endfunction

  task automatic check(input string req, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b0; regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic runFrame(input int bus, input logic [31:0] c, input logic [15:0] w,
                          input logic [63:0] pat, input int hookAt,
                          input logic [31:0] hook0, input bit hook1En,
                          input logic [31:0] hook1,
                          output logic [63:0] capOut, output logic [63:0] capOe,
                          output int busyCyc, output int riseCnt, output int period,
                          output int otherMdc, output logic endIdle);
    int firstR, secondR;
    logic prevM, bsy, hookNow;
    wr(dataA(bus), {16'b0, w});
    wr(ctrlA(bus), c & ~LOADB);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = ctrlA(bus); regWrData = c | LOADB;
    capOut = '0; capOe = '0; busyCyc = 0; riseCnt = 0; otherMdc = 0;
    firstR = 0; secondR = 0; prevM = 1'b0; endIdle = 1'b0;
    for (int cyc = 0; cyc < 5000; cyc++) begin
      @(negedge clk);
      regWrEn = 1'b0; regAddr = statA(bus); hookNow = 1'b0;
      if (busyCyc == hookAt) begin
        regWrEn = 1'b1; regAddr = ctrlA(bus); regWrData = hook0; hookNow = 1'b1;
      end else if (hook1En && busyCyc == hookAt + 1) begin
        regWrEn = 1'b1; regAddr = ctrlA(bus); regWrData = hook1; hookNow = 1'b1;
      end
      #1;
      bsy = hookNow ? 1'b1 : regRdData[16];
      if (!bsy) begin
        endIdle = !mdc[bus] && !mdioOe[bus];
        break;
      end
      busyCyc++;
      if (mdc[bus] && !prevM) begin
        if (riseCnt < 64) begin
          capOut[63 - riseCnt] = mdioOut[bus];
          capOe[63 - riseCnt]  = mdioOe[bus];
        end
        if (riseCnt == 0) firstR = cyc;
        if (riseCnt == 1) secondR = cyc;
        riseCnt++;
      end
      prevM = mdc[bus];
      for (int o = 0; o < NBUS; o++) if (o != bus && mdc[o]) otherMdc++;
      if (riseCnt < 64) mdioIn[bus] = pat[63 - riseCnt];
    end
    regWrEn = 1'b0;
    mdioIn = '1;
    period = secondR - firstR;
  endtask

  task automatic fullFrame(input int bus, input logic [31:0] c, input logic [15:0] w,
                           input logic [63:0] pat);
    logic [63:0] co, coe, mask;
    int bc, rc, per, oth, hp;
    logic idle;
    logic [31:0] st;
    bit isRd;
    isRd = (c[11:10] == 2'd2);
    hp = halfOf(c);
    mask = isRd ? {{46{1'b1}}, 18'b0} : '1;
    runFrame(bus, c, w, pat, -1, '0, 1'b0, '0, co, coe, bc, rc, per, oth, idle);
    check("R3", "frame bits", co & mask, expFrame(c, w) & mask);
    check(isRd ? "R5" : "R10", "oe per bit", coe, mask);
    check("R4", "mdc period", 64'(per), 64'(2 * hp));
    check("R6", "busy cycles", 64'(bc), 64'(128 * hp));
    check("R3", "rising count", 64'(rc), 64'd64);
    check("R4", "idle after frame", 64'(idle), 64'd1);
    check("R9", "other bus mdc", 64'(oth), 64'd0);
    if (isRd) expRd[bus] = pat[15:0];
    rd(statA(bus), st);
    check(isRd ? "R5" : "R10", "status after frame", 64'(st), {47'b0, 1'b0, expRd[bus]});
  endtask

  initial begin
    #(200000 * 5);
    checks++; failures++;
    $display("FAIL watchdog all-R actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d, c;
    logic [63:0] co, coe;
    int bc, rc, per, oth;
    logic idle;
    int seedDummy;
    seedDummy = $urandom(32'd4711);
    for (int b = 0; b < NBUS; b++) expRd[b] = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int b = 0; b < NBUS; b++) begin
      rd(ctrlA(b), d); check("R1", "ctrl reset", 64'(d), 64'd0);
      rd(dataA(b), d); check("R1", "data reset", 64'(d), 64'd0);
      rd(statA(b), d); check("R1", "stat reset", 64'(d), 64'd0);
    end
    check("R1", "mdc reset", 64'(mdc), 64'd0);
    check("R1", "oe reset", 64'(mdioOe), 64'd0);

    // directed write on bus0, fastest divider
    fullFrame(0, mkCtrl(5'h15, 5'h0A, 2'd1, 4'd0, 2'd0), 16'hA55A, 64'h0);
    // directed read on bus1 (R9 address stride)
    fullFrame(1, mkCtrl(5'h03, 5'h11, 2'd2, 4'd0, 2'd0), 16'h0, 64'h0000_0000_0000_C3E1);
    rd(dataA(1), d); check("R9", "bus1 data reg", 64'(d), 64'h0);
    rd(dataA(0), d); check("R9", "bus0 data reg kept", 64'(d), 64'hA55A);
    // divider variants
    fullFrame(0, mkCtrl(5'h01, 5'h02, 2'd2, 4'd2, 2'd1), 16'h1234, 64'h0000_0000_0000_7F01);
    fullFrame(1, mkCtrl(5'h1F, 5'h1F, 2'd1, 4'd7, 2'd1), 16'hFFFF, 64'h0);
    // R10 other opcodes drive the whole frame
    fullFrame(0, mkCtrl(5'h04, 5'h05, 2'd3, 4'd0, 2'd0), 16'h0F0F, 64'hFFFF);
    fullFrame(1, mkCtrl(5'h06, 5'h07, 2'd0, 4'd1, 2'd0), 16'h8001, 64'h5555);

    // R2 stale launch bit: stored bit 24 is set, a new set does nothing
    wr(ctrlA(0), mkCtrl(5'h09, 5'h09, 2'd1, 4'd0, 2'd0) | LOADB);
    oth = 0;
    for (int i = 0; i < 40; i++) begin
      rd(statA(0), d);
      if (d[16] || mdc[0]) oth++;
    end
    check("R2", "no start on stale load", 64'(oth), 64'd0);
    fullFrame(0, mkCtrl(5'h09, 5'h09, 2'd1, 4'd0, 2'd0), 16'h7E7E, 64'h0);

    // R7 launch edge while busy is ignored
    c = mkCtrl(5'h12, 5'h13, 2'd1, 4'd1, 2'd0);
    runFrame(0, c, 16'hBEEF, 64'h0, 50, mkCtrl(5'h00, 5'h00, 2'd2, 4'd5, 2'd0), 1'b1,
             mkCtrl(5'h00, 5'h00, 2'd2, 4'd5, 2'd0) | LOADB,
             co, coe, bc, rc, per, oth, idle);
    check("R7", "frame unchanged", co, expFrame(c, 16'hBEEF));
    check("R7", "busy length unchanged", 64'(bc), 64'(128 * 2));
    check("R7", "oe unchanged", coe, '1);

    // R8 soft reset mid-frame
    c = mkCtrl(5'h0C, 5'h0D, 2'd2, 4'd3, 2'd1);
    runFrame(1, c, 16'h0, 64'hFFFF, 100, c | RSTB, 1'b0, '0,
             co, coe, bc, rc, per, oth, idle);
    check("R8", "busy ends next edge", 64'(bc), 64'd101);
    check("R8", "idle after abort", 64'(idle), 64'd1);
    wr(ctrlA(1), c);
    rd(ctrlA(1), d);
    check("R8", "divider kept", 64'(d[21:16]), 64'(c[21:16]));
    rd(statA(1), d);
    check("R8", "idle after release", 64'(d), {47'b0, 1'b0, expRd[1]});
    fullFrame(1, mkCtrl(5'h0C, 5'h0D, 2'd2, 4'd0, 2'd0), 16'h0, 64'h0000_0000_0000_2468);

    // random frames
    for (int n = 0; n < 10; n++) begin
      int bus;
      logic [63:0] pat;
      bus = int'($urandom_range(0, NBUS - 1));
      pat = {$urandom(), $urandom()};
      c = mkCtrl(5'($urandom()), 5'($urandom()), 2'($urandom()),
                 4'($urandom_range(0, 3)), 2'($urandom_range(0, 1)));
      fullFrame(bus, c, 16'($urandom()), pat);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule